// File: doc/BRIEF.md
# Debug Readout Protection Level Controller

This block holds a three-step readout protection setting for an on-chip debug port and applies it. After reset it takes its starting level from a non-volatile option value. Until that load happens it behaves as if the top level were set. It judges every access to the code flash, to a protected SRAM window and to the backup registers. Each access is granted, or answered with a bus error one cycle later. The verdict depends on the level, on whether the debug port or user code issued the access, and on which boot source is active. It also drives the enables for the debug port features and gates writes to the other option values.

Software or a debugger asks for a new level through a one-cycle request. Raising the level takes effect on the next cycle. Lowering is possible only from the middle level to the lowest one. It first runs an erase handshake that covers the flash, the protected SRAM and the backup registers. The new level is committed only after the erase reports completion. The top level cannot be left, and while it is set every option value is frozen. Any request that would stay at the current level, or that describes an illegal move, is refused with a one-cycle error pulse.

Top module: `prot_level_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `level_o` reads 2'b10 and `debug_en_o` is all zeros. The option value is loaded at the first clock edge after reset is released.
- R2: The loaded option value decodes as 2'b00 to level 0, 2'b01 to level 1 and 2'b10 to level 2. The unused code 2'b11 decodes to level 2.
- R3: At level 0, every access is granted. `rsp_valid_o` is high in the cycle after `acc_valid_i` is sampled, with `rsp_err_o` low.
- R4: At levels 1 and 2, a debug-port access (`acc_dbg_i`=1) to flash (region 2'b01) or to the protected SRAM (region 2'b10) gets `rsp_err_o`=1. Debug accesses to the general region (2'b00) and to the backup region (2'b11) are granted.
- R5: At levels 1 and 2, a user-code access to flash or to the protected SRAM is granted only when the boot source is flash (2'b00). With the SRAM (2'b01), system bootloader (2'b10) or reserved (2'b11) boot source it gets a bus error. User accesses to the general and backup regions are granted.
- R6: Outside the post-reset load cycle, `debug_en_o` is all ones at levels 0 and 1 and all zeros at level 2.
- R7: A request for a higher level (1 or 2) from a lower one is accepted. `level_o` shows the new level in the next cycle and `req_err_o` stays low.
- R8: The following requests are refused: a request for the current level, a request for target 2'b11, any request at level 2, and any request during the load cycle or an erase. A refused request raises `req_err_o` for exactly the next cycle and leaves the level unchanged.
- R9: A request for level 0 from level 1 starts the erase. From the next cycle all `erase_req_o` bits are high and `level_o` stays 1. The cycle after `erase_done_i` is sampled high, `level_o` is 0 and `erase_req_o` is low. Outside an erase, `erase_done_i` has no effect.
- R10: During an erase, every debug access is refused. A user access is refused unless it targets the general region (2'b00).
- R11: `opt_wr_en_o` follows `opt_wr_i` in the same cycle only when no erase is running, the load cycle is over and the level is below 2. Otherwise it is low.
- R12: When an access and a level request are sampled at the same edge, the access is judged under the level and state that held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| opt_level_i | input | 2 | Non-volatile level option, loaded after reset |
| req_valid_i | input | 1 | Level-change request strobe |
| req_level_i | input | 2 | Requested target level |
| req_err_o | output | 1 | One-cycle pulse for a refused request |
| level_o | output | 2 | Current protection level |
| erase_req_o | output | N_ERASE_RGN | Erase request per region (flash, protected SRAM, backup) |
| erase_done_i | input | 1 | Erase completion from the memory side |
| acc_valid_i | input | 1 | Access to be judged |
| acc_dbg_i | input | 1 | Access comes from the debug port (1) or user code (0) |
| acc_region_i | input | 2 | Target region: 00 general, 01 flash, 10 protected SRAM, 11 backup |
| boot_src_i | input | 2 | Boot source: 00 flash, 01 SRAM, 10 system bootloader, 11 reserved |
| rsp_valid_o | output | 1 | Verdict valid, one cycle after the access |
| rsp_err_o | output | 1 | Verdict is a bus error |
| debug_en_o | output | N_DBG_FEAT | Enables: bit 0 JTAG, 1 wire trace, 2 instruction trace, 3 boundary scan |
| opt_wr_i | input | 1 | Write request to the other option values |
| opt_wr_en_o | output | 1 | Gated option write |

## Verification
The level-change path and the access check can act at the same clock edge. In that case the verdict must come from the level that held before the edge, not the one being written. The bench provokes this overlap in two ways. It raises level 0 to level 1 while a debug flash read is sampled, and it starts an erase from level 1 while a debug flash read is sampled. In the first case the read must be granted and the very next identical read refused. In the second case the read must be refused under the old level 1, and the erase must then be in progress.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int LVL_W = 2;
    localparam int RGN_W = 2;
    localparam int BOOT_W = 2;

    localparam logic [LVL_W-1:0] LVL0 = 2'b00;
    localparam logic [LVL_W-1:0] LVL1 = 2'b01;
    localparam logic [LVL_W-1:0] LVL2 = 2'b10;
    localparam logic [LVL_W-1:0] LVL_BAD = 2'b11;

    localparam logic [RGN_W-1:0] RGN_GEN = 2'b00;
    localparam logic [RGN_W-1:0] RGN_FLASH = 2'b01;
    localparam logic [RGN_W-1:0] RGN_PSRAM = 2'b10;
    localparam logic [RGN_W-1:0] RGN_BKUP = 2'b11;

    localparam logic [BOOT_W-1:0] BOOT_FLASH = 2'b00;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'b00,
        ST_RUN   = 2'b01,
        ST_ERASE = 2'b10
    } prot_st_e;

    // Anything that is not a known lower level fails secure to the top level.
    function automatic logic [LVL_W-1:0] sanitize_lvl(input logic [LVL_W-1:0] raw);
        logic [LVL_W-1:0] res;
        case (raw)
            LVL0:    res = LVL0;
            LVL1:    res = LVL1;
            default: res = LVL2;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/prot_level_fsm.sv
module prot_level_fsm
    import prot_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LVL_W-1:0]  opt_level_i,
    input  logic              req_valid_i,
    input  logic [LVL_W-1:0]  req_level_i,
    input  logic              erase_done_i,
    output prot_st_e          st_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              req_err_o
);

    typedef struct packed {
        prot_st_e          st;
        logic [LVL_W-1:0]  lvl;
        logic              err;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: ST_LOAD, lvl: LVL2, err: 1'b0};

    fsm_t fsm_d, fsm_q;
    logic req_bad;

    always_comb begin
        req_bad = (fsm_q.lvl == LVL2) || (req_level_i == LVL_BAD) ||
                  (req_level_i == fsm_q.lvl);
        fsm_d     = fsm_q;
        fsm_d.err = 1'b0;
        case (fsm_q.st)
            ST_LOAD: begin
                fsm_d.st  = ST_RUN;
                fsm_d.lvl = sanitize_lvl(opt_level_i);
                fsm_d.err = req_valid_i;
            end
            ST_RUN: begin
                if (req_valid_i) begin
                    if (req_bad) begin
                        fsm_d.err = 1'b1;
                    end else if (req_level_i > fsm_q.lvl) begin
                        fsm_d.lvl = req_level_i;
                    end else begin
                        // only level 1 -> level 0 reaches here
                        fsm_d.st = ST_ERASE;
                    end
                end
            end
            ST_ERASE: begin
                fsm_d.err = req_valid_i;
                if (erase_done_i) begin
                    fsm_d.st  = ST_RUN;
                    fsm_d.lvl = LVL0;
                end
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsm_q <= FSM_RST;
        else         fsm_q <= fsm_d;
    end

    assign st_o      = fsm_q.st;
    assign level_o   = fsm_q.lvl;
    assign req_err_o = fsm_q.err;

endmodule

// File: rtl/prot_access_chk.sv
module prot_access_chk
    import prot_pkg::*;
(
    input  prot_st_e           st_i,
    input  logic [LVL_W-1:0]   level_i,
    input  logic               acc_dbg_i,
    input  logic [RGN_W-1:0]   acc_region_i,
    input  logic [BOOT_W-1:0]  boot_src_i,
    output logic               deny_o
);

    logic guarded;
    logic user_ok;

    always_comb begin
        guarded = (acc_region_i == RGN_FLASH) || (acc_region_i == RGN_PSRAM);
        user_ok = (boot_src_i == BOOT_FLASH);
        if (st_i == ST_ERASE) begin
            deny_o = acc_dbg_i || (acc_region_i != RGN_GEN);
        end else if (level_i == LVL0) begin
            deny_o = 1'b0;
        end else begin
            // load cycle carries level 2, so it falls here as well
            deny_o = guarded && (acc_dbg_i || !user_ok);
        end
    end

endmodule

// File: rtl/prot_dbg_gate.sv
module prot_dbg_gate
    import prot_pkg::*;
#(
    parameter int N_DBG_FEAT = 4
) (
    input  prot_st_e                st_i,
    input  logic [LVL_W-1:0]        level_i,
    input  logic                    opt_wr_i,
    output logic [N_DBG_FEAT-1:0]   debug_en_o,
    output logic                    opt_wr_en_o
);

    logic feat_ok;
    logic opt_open;

    assign feat_ok  = (st_i != ST_LOAD) && (level_i != LVL2);
    assign opt_open = (st_i == ST_RUN) && (level_i != LVL2);

    for (genvar g = 0; g < N_DBG_FEAT; g++) begin : g_feat
        assign debug_en_o[g] = feat_ok;
    end

    assign opt_wr_en_o = opt_wr_i && opt_open;

endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
    import prot_pkg::*;
#(
    parameter int N_DBG_FEAT  = 4,
    parameter int N_ERASE_RGN = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [1:0]               opt_level_i,
    input  logic                     req_valid_i,
    input  logic [1:0]               req_level_i,
    output logic                     req_err_o,
    output logic [1:0]               level_o,
    output logic [N_ERASE_RGN-1:0]   erase_req_o,
    input  logic                     erase_done_i,
    input  logic                     acc_valid_i,
    input  logic                     acc_dbg_i,
    input  logic [1:0]               acc_region_i,
    input  logic [1:0]               boot_src_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_err_o,
    output logic [N_DBG_FEAT-1:0]    debug_en_o,
    input  logic                     opt_wr_i,
    output logic                     opt_wr_en_o
);

    typedef struct packed {
        logic vld;
        logic err;
    } rsp_t;

    prot_st_e         fsm_st;
    logic [LVL_W-1:0] fsm_lvl;
    logic             deny;
    rsp_t             rsp_d, rsp_q;

    prot_level_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .opt_level_i  (opt_level_i),
        .req_valid_i  (req_valid_i),
        .req_level_i  (req_level_i),
        .erase_done_i (erase_done_i),
        .st_o         (fsm_st),
        .level_o      (fsm_lvl),
        .req_err_o    (req_err_o)
    );

    prot_access_chk u_chk (
        .st_i         (fsm_st),
        .level_i      (fsm_lvl),
        .acc_dbg_i    (acc_dbg_i),
        .acc_region_i (acc_region_i),
        .boot_src_i   (boot_src_i),
        .deny_o       (deny)
    );

    prot_dbg_gate #(.N_DBG_FEAT(N_DBG_FEAT)) u_gate (
        .st_i        (fsm_st),
        .level_i     (fsm_lvl),
        .opt_wr_i    (opt_wr_i),
        .debug_en_o  (debug_en_o),
        .opt_wr_en_o (opt_wr_en_o)
    );

    always_comb begin
        rsp_d.vld = acc_valid_i;
        rsp_d.err = acc_valid_i && deny;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    for (genvar r = 0; r < N_ERASE_RGN; r++) begin : g_erase
        assign erase_req_o[r] = (fsm_st == ST_ERASE);
    end

    assign level_o     = fsm_lvl;
    assign rsp_valid_o = rsp_q.vld;
    assign rsp_err_o   = rsp_q.err;

endmodule

// File: rtl/prot_level_ctrl_chk.sv
module prot_level_ctrl_chk
    import prot_pkg::*;
#(
    parameter int N_DBG_FEAT  = 4,
    parameter int N_ERASE_RGN = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  prot_st_e                st_i,
    input  logic [1:0]              level_o,
    input  logic [N_DBG_FEAT-1:0]   debug_en_o,
    input  logic [N_ERASE_RGN-1:0]  erase_req_o,
    input  logic                    erase_done_i,
    input  logic                    acc_dbg_i,
    input  logic                    rsp_valid_o,
    input  logic                    rsp_err_o,
    input  logic                    opt_wr_en_o
);

    // R6: top level switches every debug feature off
    a_r6_top_dbg_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == LVL2) |-> (debug_en_o == '0));

    // R8: once running at level 2, the level never changes
    a_r8_top_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == LVL2 && st_i != ST_LOAD) |=> (level_o == LVL2));

    // R9: erase runs only while the middle level is held
    a_r9_erase_at_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_req_o[0] |-> (level_o == LVL1));

    // R9: erase completion commits the lowest level
    a_r9_erase_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (erase_req_o[0] && erase_done_i) |=> (level_o == LVL0 && !erase_req_o[0]));

    // R10: debug accesses during erase are refused
    a_r10_erase_dbg_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && $past(erase_req_o[0]) && $past(acc_dbg_i)) |-> rsp_err_o);

    // R11: option writes blocked at the top level
    a_r11_opt_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == LVL2) |-> !opt_wr_en_o);

    // R3: lowest level never produces a bus error
    a_r3_open_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && $past(level_o) == LVL0 && $past(st_i) == ST_RUN) |-> !rsp_err_o);

endmodule

bind prot_level_ctrl prot_level_ctrl_chk #(
    .N_DBG_FEAT  (N_DBG_FEAT),
    .N_ERASE_RGN (N_ERASE_RGN)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_i         (fsm_st),
    .level_o      (level_o),
    .debug_en_o   (debug_en_o),
    .erase_req_o  (erase_req_o),
    .erase_done_i (erase_done_i),
    .acc_dbg_i    (acc_dbg_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_err_o    (rsp_err_o),
    .opt_wr_en_o  (opt_wr_en_o)
);

// File: tb/prot_level_ctrl_tb.sv
`timescale 1ns/1ps
module prot_level_ctrl_tb_top;

    localparam int NF = 4;
    localparam int NE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    opt_level = 2'b00;
    logic          req_valid = 1'b0;
    logic [1:0]    req_level = 2'b00;
    logic          req_err;
    logic [1:0]    level;
    logic [NE-1:0] erase_req;
    logic          erase_done = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_dbg = 1'b0;
    logic [1:0]    acc_region = 2'b00;
    logic [1:0]    boot_src = 2'b00;
    logic          rsp_valid;
    logic          rsp_err;
    logic [NF-1:0] debug_en;
    logic          opt_wr = 1'b0;
    logic          opt_wr_en;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prot_level_ctrl #(.N_DBG_FEAT(NF), .N_ERASE_RGN(NE)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .opt_level_i  (opt_level),
        .req_valid_i  (req_valid),
        .req_level_i  (req_level),
        .req_err_o    (req_err),
        .level_o      (level),
        .erase_req_o  (erase_req),
        .erase_done_i (erase_done),
        .acc_valid_i  (acc_valid),
        .acc_dbg_i    (acc_dbg),
        .acc_region_i (acc_region),
        .boot_src_i   (boot_src),
        .rsp_valid_o  (rsp_valid),
        .rsp_err_o    (rsp_err),
        .debug_en_o   (debug_en),
        .opt_wr_i     (opt_wr),
        .opt_wr_en_o  (opt_wr_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int dec_lvl(input int v);
        return (v == 0) ? 0 : (v == 1) ? 1 : 2;
    endfunction

    // Expected verdict from the requirements (R3, R4, R5, R10)
    function automatic int exp_deny(input int lvl, input bit erasing, input int dbg,
                                    input int rgn, input int boot);
        bit guarded;
        guarded = (rgn == 1) || (rgn == 2);
        if (erasing) return (dbg == 1 || rgn != 0) ? 1 : 0;
        if (lvl == 0) return 0;
        return (guarded && (dbg == 1 || boot != 0)) ? 1 : 0;
    endfunction

    task automatic do_reset(input int opt);
        rst_n = 1'b0; opt_level = opt[1:0]; req_valid = 1'b0; acc_valid = 1'b0;
        erase_done = 1'b0; opt_wr = 1'b0;
        tick(); tick();
        chk("R1 level during reset", int'(level), 2);
        chk("R1 debug enables during reset", int'(debug_en), 0);
        rst_n = 1'b1;
        tick();
        chk("R2 loaded level", int'(level), dec_lvl(opt));
    endtask

    task automatic do_acc(input string tag, input int dbg, input int rgn,
                          input int boot, input int exp);
        acc_valid = 1'b1; acc_dbg = dbg[0]; acc_region = rgn[1:0]; boot_src = boot[1:0];
        tick();
        acc_valid = 1'b0;
        chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " rsp_err"}, int'(rsp_err), exp);
    endtask

    task automatic do_req(input int tgt);
        req_valid = 1'b1; req_level = tgt[1:0];
        tick();
        req_valid = 1'b0;
    endtask

    initial begin : wdog
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int lv;
        // Sweep every option value, then every access combination at that level
        for (int o = 0; o < 4; o++) begin
            do_reset(o);
            lv = dec_lvl(o);
            chk("R6 debug enables", int'(debug_en), (lv == 2) ? 0 : 15);
            opt_wr = 1'b1; #1;
            chk("R11 option write gate", int'(opt_wr_en), (lv == 2) ? 0 : 1);
            opt_wr = 1'b0;
            for (int d = 0; d < 2; d++)
                for (int r = 0; r < 4; r++)
                    for (int b = 0; b < 4; b++)
                        do_acc((lv == 0) ? "R3 open access" :
                               (d == 1) ? "R4 debug access" : "R5 user access",
                               d, r, b, exp_deny(lv, 1'b0, d, r, b));
        end

        // Sweep every request from every starting level
        for (int o = 0; o < 3; o++) begin
            for (int t = 0; t < 4; t++) begin
                bit rej;
                do_reset(o);
                rej = (o == 2) || (t == 3) || (t == o);
                do_req(t);
                chk(rej ? "R8 refused request err" : "R7 accepted request err",
                    int'(req_err), rej ? 1 : 0);
                chk(rej ? "R8 level kept" : "R7 level after request", int'(level),
                    (rej || t < o) ? o : t);
                chk("R9 erase request", int'(erase_req), (!rej && t < o) ? 7 : 0);
                tick();
                chk("R8 error pulse ends", int'(req_err), 0);
            end
        end

        // Request during the load cycle
        rst_n = 1'b0; opt_level = 2'b00; tick();
        rst_n = 1'b1; req_valid = 1'b1; req_level = 2'b01;
        tick(); req_valid = 1'b0;
        chk("R8 request in load cycle err", int'(req_err), 1);
        chk("R8 request in load cycle level", int'(level), 0);

        // Full erase sequence
        do_reset(1);
        erase_done = 1'b1; tick(); erase_done = 1'b0;
        chk("R9 done ignored outside erase", int'(level), 1);
        do_req(0);
        chk("R9 erase started", int'(erase_req), 7);
        for (int d = 0; d < 2; d++)
            for (int r = 0; r < 4; r++)
                do_acc("R10 access during erase", d, r, 0, exp_deny(1, 1'b1, d, r, 0));
        opt_wr = 1'b1; #1;
        chk("R11 option write during erase", int'(opt_wr_en), 0);
        opt_wr = 1'b0;
        do_req(2);
        chk("R8 request during erase err", int'(req_err), 1);
        chk("R9 level held during erase", int'(level), 1);
        tick(); tick();
        chk("R9 still erasing", int'(erase_req), 7);
        erase_done = 1'b1; tick(); erase_done = 1'b0;
        chk("R9 level after erase", int'(level), 0);
        chk("R9 erase released", int'(erase_req), 0);
        do_acc("R9 debug flash after erase", 1, 1, 1, 0);

        // Same-edge access and level request
        do_reset(0);
        req_valid = 1'b1; req_level = 2'b01;
        acc_valid = 1'b1; acc_dbg = 1'b1; acc_region = 2'b01; boot_src = 2'b00;
        tick(); req_valid = 1'b0; acc_valid = 1'b0;
        chk("R12 access judged on old level", int'(rsp_err), 0);
        chk("R12 raise applied", int'(level), 1);
        do_acc("R12 next access on new level", 1, 1, 0, 1);

        do_reset(1);
        req_valid = 1'b1; req_level = 2'b00;
        acc_valid = 1'b1; acc_dbg = 1'b1; acc_region = 2'b01; boot_src = 2'b00;
        tick(); req_valid = 1'b0; acc_valid = 1'b0;
        chk("R12 access before erase refused", int'(rsp_err), 1);
        chk("R12 erase began", int'(erase_req), 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule